// File: doc/BRIEF.md
# USB Endpoint-0 Control Transfer Stage Manager

This block runs the device side of control transfers on endpoint 0 of a full-speed USB function. An upstream protocol engine hands it decoded events: SETUP, IN and OUT tokens, payload bytes with an end-of-packet strobe, a host ACK and a bus reset. The block collects the eight request bytes, moves the transfer through setup, data and status stages, and answers each IN token or data packet with a handshake code that the protocol engine turns into wire traffic.

The standard Set Address and Set Configuration requests are completed in hardware, which also tracks the device state (powered, default, addressed, configured). Every other request is left to the CPU. The CPU reads the captured request through a small register file, preloads or drains the endpoint buffer, and then sets a completion-grant bit. The zero-length status handshake is held off with NAK until that grant is set. Sticky, maskable interrupt causes report stage changes, device-state changes and transfer completion.

Top module: `usb_ctl_stage_mgr`

## Requirements
- R1: After reset the device state is powered (dev_state_o=0), the address is 0, the stage is idle (stage_o=0), no cause is pending, irq_o is low and ep0_units_o is 1. While the state is powered, every event except bus reset is ignored and produces no response.
- R2: A bus reset sets the state to default (1), the address to 0 and the stage to idle, clears the grant bit, and sets the device-state cause (bit 1 of the cause register at CPU address 4).
- R3: After a SETUP token, an 8-byte data packet ends with an ACK response. The bytes go into CPU registers in little-endian order: address 0 holds {byte1, byte0}, address 1 holds {byte3, byte2}, address 2 holds {byte5, byte4} and address 3 holds {byte7, byte6}. A SETUP packet of any other length gets no response and leaves those registers unchanged.
- R4: Once the setup stage ends, the next stage is chosen as follows. Type 0x00 with request 5 or 9 goes to status-IN (4) as a hardware request. A length of 0 also goes to status-IN. Type bit 7 set goes to data-IN (2). Anything else goes to data-OUT (3). Every stage change sets the stage cause (bit 0). stage_o never exceeds 5.
- R5: In data-IN, an IN token is answered with DATA when in_ready_i is high and with NAK otherwise, and a host ACK leaves the stage unchanged. An OUT token moves the stage to status-OUT (5).
- R6: In data-OUT, a data packet is answered with ACK when out_room_i is high and with NAK otherwise. An IN token moves the stage to status-IN and is answered as a status-stage IN.
- R7: The grant bit is bit 0 of the control register at CPU address 4'd6, and bits 4:1 of that register drive ep0_units_o. A status-IN token is answered with ZLP only when the grant bit is set or the request is a hardware request, and with NAK otherwise. Writing the grant bit during the setup stage has no effect. Every SETUP token clears the grant bit.
- R8: A host ACK after a ZLP in status-IN, or an ACKed zero-length packet in status-OUT, returns the stage to idle and sets the done cause (bit 2).
- R9: Set Address keeps dev_addr_o unchanged until the host ACKs the status ZLP. It then loads wValue[6:0], sets the state to addressed (2), or to default if the value is 0, and sets the device-state cause.
- R10: Set Configuration completes with the state configured (3) for a nonzero wValue[7:0] and addressed (2) for zero, and sets the device-state cause. In the default state the device state does not change.
- R11: A SETUP token in any stage moves the stage to setup (1) at once, and the new request overwrites the request registers.
- R12: Cause bits are sticky and cleared by writing 1 to them at address 4. The mask is at address 5. irq_o is high exactly when some pending cause is unmasked.
- R13: resp_valid_o pulses for one cycle, in the cycle after the IN token or end-of-packet it answers. The response codes are ACK=0, NAK=1, DATA=2 and ZLP=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_reset_i | input | 1 | USB bus reset seen (pulse) |
| tok_setup_i | input | 1 | SETUP token for endpoint 0 (pulse) |
| tok_in_i | input | 1 | IN token for endpoint 0 (pulse) |
| tok_out_i | input | 1 | OUT token for endpoint 0 (pulse) |
| rx_valid_i | input | 1 | Payload byte strobe |
| rx_byte_i | input | 8 | Payload byte |
| rx_end_i | input | 1 | Good end of data packet (pulse) |
| host_ack_i | input | 1 | Host ACKed the last IN data (pulse) |
| in_ready_i | input | 1 | Endpoint buffer holds an IN packet |
| out_room_i | input | 1 | Endpoint buffer can take an OUT packet |
| cpu_we_i | input | 1 | CPU register write strobe |
| cpu_addr_i | input | 4 | CPU register address |
| cpu_wdata_i | input | 16 | CPU write data |
| cpu_rdata_o | output | 16 | CPU read data (combinational) |
| resp_valid_o | output | 1 | Response code valid (pulse) |
| resp_code_o | output | 2 | Handshake to send: ACK, NAK, DATA, ZLP |
| dev_addr_o | output | 7 | Current device address |
| dev_state_o | output | 2 | Device state |
| stage_o | output | 3 | Control transfer stage |
| ep0_units_o | output | 4 | Endpoint 0 buffer size in 64-byte units |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a hardware request whose status stage sits waiting while the address or configuration must not yet change. The observation has to fall between the ZLP answer and the host ACK. The bench drives Set Address and then Set Configuration and reads dev_addr_o and dev_state_o after each of those two events. A sweep over request type, request number, length and buffer readiness covers every branch of the next-stage choice and the first IN answer in each stage. Grant writes made during the setup stage, and SETUP tokens that land mid-transfer, are provoked on purpose.

// File: rtl/usb_ctl_pkg.sv
package usb_ctl_pkg;

    localparam int SETUP_BYTES = 8;
    localparam int CPU_DW      = 16;
    localparam int CPU_AW      = 4;
    localparam int NUM_CAUSE   = 3;

    localparam int CAUSE_STAGE = 0;
    localparam int CAUSE_DEV   = 1;
    localparam int CAUSE_DONE  = 2;

    localparam logic [7:0] REQ_SET_ADDRESS = 8'h05;
    localparam logic [7:0] REQ_SET_CONFIG  = 8'h09;

    localparam logic [CPU_AW-1:0] RA_REQ    = 4'd0;
    localparam logic [CPU_AW-1:0] RA_VALUE  = 4'd1;
    localparam logic [CPU_AW-1:0] RA_INDEX  = 4'd2;
    localparam logic [CPU_AW-1:0] RA_LENGTH = 4'd3;
    localparam logic [CPU_AW-1:0] RA_CAUSE  = 4'd4;
    localparam logic [CPU_AW-1:0] RA_MASK   = 4'd5;
    localparam logic [CPU_AW-1:0] RA_CTL    = 4'd6;
    localparam logic [CPU_AW-1:0] RA_STATUS = 4'd7;
    localparam logic [CPU_AW-1:0] RA_ADDR   = 4'd8;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_DIN   = 3'd2,
        ST_DOUT  = 3'd3,
        ST_SIN   = 3'd4,
        ST_SOUT  = 3'd5
    } stage_e;

    typedef enum logic [1:0] {
        DV_POWERED    = 2'd0,
        DV_DEFAULT    = 2'd1,
        DV_ADDRESS    = 2'd2,
        DV_CONFIGURED = 2'd3
    } dev_e;

    typedef enum logic [1:0] {
        RS_ACK  = 2'd0,
        RS_NAK  = 2'd1,
        RS_DATA = 2'd2,
        RS_ZLP  = 2'd3
    } resp_e;

    typedef enum logic [1:0] {
        PK_NONE  = 2'd0,
        PK_SETUP = 2'd1,
        PK_OUT   = 2'd2,
        PK_IN    = 2'd3
    } pkt_e;

    // byte 0 sits in the least significant bits
    typedef struct packed {
        logic [15:0] length;
        logic [15:0] index;
        logic [15:0] value;
        logic [7:0]  breq;
        logic [7:0]  rtype;
    } setup_s;

    function automatic logic hw_request(setup_s s);
        return (s.rtype == 8'h00) &&
               ((s.breq == REQ_SET_ADDRESS) || (s.breq == REQ_SET_CONFIG));
    endfunction

    function automatic stage_e stage_after_setup(setup_s s);
        if (hw_request(s) || (s.length == 16'd0)) return ST_SIN;
        else if (s.rtype[7])                        return ST_DIN;
        else                                        return ST_DOUT;
    endfunction

endpackage

// File: rtl/usb_ctl_capture.sv
module usb_ctl_capture #(
    parameter int NBYTES = 8,
    localparam int CNT_W = $clog2(NBYTES + 2)
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                pkt_start_i,
    input  logic                byte_valid_i,
    input  logic [7:0]          byte_i,
    output logic [CNT_W-1:0]    count_o,
    output logic [NBYTES*8-1:0] shadow_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NBYTES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)                                  cnt_q <= '0;
        else if (pkt_start_i)                       cnt_q <= '0;
        else if (byte_valid_i && (cnt_q != CNT_MAX)) cnt_q <= cnt_q + 1'b1;
    end

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        always_ff @(posedge clk_i) begin
            if (rst_i)
                shadow_o[g*8 +: 8] <= '0;
            else if (!pkt_start_i && byte_valid_i && (cnt_q == CNT_W'(g)))
                shadow_o[g*8 +: 8] <= byte_i;
        end
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/usb_ctl_stage_fsm.sv
module usb_ctl_stage_fsm
    import usb_ctl_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int CNT_W  = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              bus_reset_i,
    input  logic              tok_setup_i,
    input  logic              tok_in_i,
    input  logic              tok_out_i,
    input  logic              rx_end_i,
    input  logic              host_ack_i,
    input  logic              in_ready_i,
    input  logic              out_room_i,
    input  logic [CNT_W-1:0]  count_i,
    input  setup_s            setup_now_i,
    input  setup_s            setup_reg_i,
    input  logic              grant_set_i,
    output stage_e            stage_o,
    output dev_e              dev_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              grant_o,
    output logic              hwreq_o,
    output logic              resp_valid_o,
    output resp_e             resp_code_o,
    output logic              setup_done_o,
    output logic [NUM_CAUSE-1:0] events_o
);
    stage_e            stage_q, stage_n;
    dev_e              dev_q, dev_n;
    logic [ADDR_W-1:0] addr_q, addr_n;
    logic              grant_q, grant_n;
    logic              hw_q, hw_n;
    logic              zlp_q, zlp_n;
    pkt_e              kind_q, kind_n;
    logic              rv_n, rv_q;
    resp_e             rc_n, rc_q;
    logic              force_stage_ev, ev_dev, ev_done;

    always_comb begin
        stage_n = stage_q;  dev_n  = dev_q;  addr_n = addr_q;
        grant_n = grant_q;  hw_n   = hw_q;   zlp_n  = zlp_q;
        kind_n  = kind_q;
        rv_n = 1'b0;  rc_n = RS_NAK;
        setup_done_o = 1'b0;
        force_stage_ev = 1'b0;  ev_dev = 1'b0;  ev_done = 1'b0;

        if (bus_reset_i) begin
            stage_n = ST_IDLE;  dev_n = DV_DEFAULT;  addr_n = '0;
            grant_n = 1'b0;  hw_n = 1'b0;  zlp_n = 1'b0;  kind_n = PK_NONE;
            ev_dev  = 1'b1;
        end else if (dev_q != DV_POWERED) begin
            if (grant_set_i && (stage_q != ST_SETUP)) grant_n = 1'b1;

            if (tok_setup_i) begin
                stage_n = ST_SETUP;  grant_n = 1'b0;  hw_n = 1'b0;
                zlp_n = 1'b0;  kind_n = PK_SETUP;  force_stage_ev = 1'b1;
            end else if (tok_out_i) begin
                kind_n = PK_OUT;
                if (stage_q == ST_DIN) stage_n = ST_SOUT;
            end else if (tok_in_i) begin
                kind_n = PK_IN;
                zlp_n  = 1'b0;
                rv_n   = 1'b1;
                unique case (stage_q)
                    ST_DIN:  rc_n = in_ready_i ? RS_DATA : RS_NAK;
                    ST_DOUT: begin
                        stage_n = ST_SIN;
                        rc_n    = grant_q ? RS_ZLP : RS_NAK;
                        zlp_n   = grant_q;
                    end
                    ST_SIN: begin
                        rc_n  = (grant_q || hw_q) ? RS_ZLP : RS_NAK;
                        zlp_n = grant_q || hw_q;
                    end
                    default: rc_n = RS_NAK;
                endcase
            end else if (rx_end_i) begin
                kind_n = PK_NONE;
                if (kind_q == PK_SETUP) begin
                    if (count_i == CNT_W'(SETUP_BYTES)) begin
                        setup_done_o = 1'b1;
                        rv_n    = 1'b1;
                        rc_n    = RS_ACK;
                        stage_n = stage_after_setup(setup_now_i);
                        hw_n    = hw_request(setup_now_i);
                    end
                end else if (kind_q == PK_OUT) begin
                    rv_n = 1'b1;
                    if (stage_q == ST_DOUT) begin
                        rc_n = out_room_i ? RS_ACK : RS_NAK;
                    end else if ((stage_q == ST_SOUT) && (count_i == '0) && grant_q) begin
                        rc_n    = RS_ACK;
                        stage_n = ST_IDLE;
                        ev_done = 1'b1;
                    end
                end
            end else if (host_ack_i && zlp_q && (stage_q == ST_SIN)) begin
                stage_n = ST_IDLE;
                zlp_n   = 1'b0;
                ev_done = 1'b1;
                if (hw_q) begin
                    hw_n   = 1'b0;
                    ev_dev = 1'b1;
                    if (setup_reg_i.breq == REQ_SET_ADDRESS) begin
                        addr_n = setup_reg_i.value[ADDR_W-1:0];
                        dev_n  = (setup_reg_i.value[ADDR_W-1:0] != '0) ? DV_ADDRESS : DV_DEFAULT;
                    end else if (dev_q != DV_DEFAULT) begin
                        dev_n  = (setup_reg_i.value[7:0] != 8'd0) ? DV_CONFIGURED : DV_ADDRESS;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stage_q <= ST_IDLE;  dev_q <= DV_POWERED;  addr_q <= '0;
            grant_q <= 1'b0;  hw_q <= 1'b0;  zlp_q <= 1'b0;
            kind_q  <= PK_NONE;  rv_q <= 1'b0;  rc_q <= RS_NAK;
        end else begin
            stage_q <= stage_n;  dev_q <= dev_n;  addr_q <= addr_n;
            grant_q <= grant_n;  hw_q <= hw_n;  zlp_q <= zlp_n;
            kind_q  <= kind_n;   rv_q <= rv_n;  rc_q <= rc_n;
        end
    end

    always_comb begin
        events_o = '0;
        events_o[CAUSE_STAGE] = (stage_n != stage_q) || force_stage_ev;
        events_o[CAUSE_DEV]   = ev_dev;
        events_o[CAUSE_DONE]  = ev_done;
    end

    assign stage_o      = stage_q;
    assign dev_o        = dev_q;
    assign addr_o       = addr_q;
    assign grant_o      = grant_q;
    assign hwreq_o      = hw_q;
    assign resp_valid_o = rv_q;
    assign resp_code_o  = rc_q;
endmodule

// File: rtl/usb_ctl_csr.sv
module usb_ctl_csr
    import usb_ctl_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int UNIT_W = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 cpu_we_i,
    input  logic [CPU_AW-1:0]    cpu_addr_i,
    input  logic [CPU_DW-1:0]    cpu_wdata_i,
    output logic [CPU_DW-1:0]    cpu_rdata_o,
    input  logic                 setup_done_i,
    input  setup_s               setup_now_i,
    input  logic [NUM_CAUSE-1:0] events_i,
    input  stage_e               stage_i,
    input  dev_e                 dev_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 grant_i,
    output setup_s               setup_reg_o,
    output logic                 grant_set_o,
    output logic [UNIT_W-1:0]    units_o,
    output logic                 irq_o
);
    setup_s               req_q;
    logic [NUM_CAUSE-1:0] pend_q, mask_q, clr;
    logic [UNIT_W-1:0]    units_q;

    assign clr = (cpu_we_i && (cpu_addr_i == RA_CAUSE)) ? cpu_wdata_i[NUM_CAUSE-1:0] : '0;
    assign grant_set_o = cpu_we_i && (cpu_addr_i == RA_CTL) && cpu_wdata_i[0];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            req_q   <= '0;
            pend_q  <= '0;
            mask_q  <= '0;
            units_q <= UNIT_W'(1);
        end else begin
            if (setup_done_i) req_q <= setup_now_i;
            pend_q <= (pend_q & ~clr) | events_i;
            if (cpu_we_i && (cpu_addr_i == RA_MASK)) mask_q  <= cpu_wdata_i[NUM_CAUSE-1:0];
            if (cpu_we_i && (cpu_addr_i == RA_CTL))  units_q <= cpu_wdata_i[UNIT_W:1];
        end
    end

    always_comb begin
        cpu_rdata_o = '0;
        unique case (cpu_addr_i)
            RA_REQ:    cpu_rdata_o = {req_q.breq, req_q.rtype};
            RA_VALUE:  cpu_rdata_o = req_q.value;
            RA_INDEX:  cpu_rdata_o = req_q.index;
            RA_LENGTH: cpu_rdata_o = req_q.length;
            RA_CAUSE:  cpu_rdata_o[NUM_CAUSE-1:0] = pend_q;
            RA_MASK:   cpu_rdata_o[NUM_CAUSE-1:0] = mask_q;
            RA_CTL:    cpu_rdata_o[UNIT_W:0] = {units_q, grant_i};
            RA_STATUS: cpu_rdata_o[4:0] = {stage_i, dev_i};
            RA_ADDR:   cpu_rdata_o[ADDR_W-1:0] = addr_i;
            default:   cpu_rdata_o = '0;
        endcase
    end

    assign setup_reg_o = req_q;
    assign units_o     = units_q;
    assign irq_o       = |(pend_q & mask_q);
endmodule

// File: rtl/usb_ctl_stage_mgr.sv
module usb_ctl_stage_mgr
    import usb_ctl_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int UNIT_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              bus_reset_i,
    input  logic              tok_setup_i,
    input  logic              tok_in_i,
    input  logic              tok_out_i,
    input  logic              rx_valid_i,
    input  logic [7:0]        rx_byte_i,
    input  logic              rx_end_i,
    input  logic              host_ack_i,
    input  logic              in_ready_i,
    input  logic              out_room_i,
    input  logic              cpu_we_i,
    input  logic [3:0]        cpu_addr_i,
    input  logic [15:0]       cpu_wdata_i,
    output logic [15:0]       cpu_rdata_o,
    output logic              resp_valid_o,
    output logic [1:0]        resp_code_o,
    output logic [ADDR_W-1:0] dev_addr_o,
    output logic [1:0]        dev_state_o,
    output logic [2:0]        stage_o,
    output logic [UNIT_W-1:0] ep0_units_o,
    output logic              irq_o
);
    localparam int CNT_W = $clog2(SETUP_BYTES + 2);

    logic [CNT_W-1:0]         count_w;
    logic [SETUP_BYTES*8-1:0] shadow_w;
    setup_s                   setup_now_w, setup_reg_w;
    stage_e                   stage_w;
    dev_e                     dev_w;
    resp_e                    rc_w;
    logic                     grant_w, hwreq_w, grant_set_w, setup_done_w;
    logic [NUM_CAUSE-1:0]     events_w;

    assign setup_now_w = setup_s'(shadow_w);

    usb_ctl_capture #(.NBYTES(SETUP_BYTES)) u_cap (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .pkt_start_i  (tok_setup_i | tok_in_i | tok_out_i),
        .byte_valid_i (rx_valid_i),
        .byte_i       (rx_byte_i),
        .count_o      (count_w),
        .shadow_o     (shadow_w)
    );

    usb_ctl_stage_fsm #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fsm (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .bus_reset_i  (bus_reset_i),
        .tok_setup_i  (tok_setup_i),
        .tok_in_i     (tok_in_i),
        .tok_out_i    (tok_out_i),
        .rx_end_i     (rx_end_i),
        .host_ack_i   (host_ack_i),
        .in_ready_i   (in_ready_i),
        .out_room_i   (out_room_i),
        .count_i      (count_w),
        .setup_now_i  (setup_now_w),
        .setup_reg_i  (setup_reg_w),
        .grant_set_i  (grant_set_w),
        .stage_o      (stage_w),
        .dev_o        (dev_w),
        .addr_o       (dev_addr_o),
        .grant_o      (grant_w),
        .hwreq_o      (hwreq_w),
        .resp_valid_o (resp_valid_o),
        .resp_code_o  (rc_w),
        .setup_done_o (setup_done_w),
        .events_o     (events_w)
    );

    usb_ctl_csr #(.ADDR_W(ADDR_W), .UNIT_W(UNIT_W)) u_csr (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .cpu_we_i     (cpu_we_i),
        .cpu_addr_i   (cpu_addr_i),
        .cpu_wdata_i  (cpu_wdata_i),
        .cpu_rdata_o  (cpu_rdata_o),
        .setup_done_i (setup_done_w),
        .setup_now_i  (setup_now_w),
        .events_i     (events_w),
        .stage_i      (stage_w),
        .dev_i        (dev_w),
        .addr_i       (dev_addr_o),
        .grant_i      (grant_w),
        .setup_reg_o  (setup_reg_w),
        .grant_set_o  (grant_set_w),
        .units_o      (ep0_units_o),
        .irq_o        (irq_o)
    );

    assign resp_code_o = rc_w;
    assign dev_state_o = dev_w;
    assign stage_o     = stage_w;
endmodule

// File: rtl/usb_ctl_stage_checks.sv
module usb_ctl_stage_checks (
    input logic       clk_i,
    input logic       rst_i,
    input logic       bus_reset_i,
    input logic       tok_setup_i,
    input logic       tok_in_i,
    input logic       rx_end_i,
    input logic       host_ack_i,
    input logic       resp_valid_o,
    input logic [1:0] resp_code_o,
    input logic [6:0] dev_addr_o,
    input logic [1:0] dev_state_o,
    input logic [2:0] stage_o,
    input logic       grant_w,
    input logic       hwreq_w
);
    AST_RESP_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
        resp_valid_o |-> $past(tok_in_i || rx_end_i)); // R13

    AST_ZLP_GRANTED: assert property (@(posedge clk_i) disable iff (rst_i)
        (resp_valid_o && resp_code_o == 2'd3) |-> $past(grant_w || hwreq_w)); // R7

    AST_SETUP_DROPS_GRANT: assert property (@(posedge clk_i) disable iff (rst_i)
        (tok_setup_i && !bus_reset_i && dev_state_o != 2'd0) |=> !grant_w); // R7

    AST_BUSRST_DEFAULT: assert property (@(posedge clk_i) disable iff (rst_i)
        bus_reset_i |=> (dev_state_o == 2'd1 && dev_addr_o == 7'd0 && stage_o == 3'd0)); // R2

    AST_POWERED_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        (dev_state_o == 2'd0 && !bus_reset_i) |=> !resp_valid_o); // R1

    AST_ADDR_ON_ACK: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(dev_addr_o) |-> $past(host_ack_i || bus_reset_i)); // R9

    AST_STAGE_LEGAL: assert property (@(posedge clk_i) disable iff (rst_i)
        stage_o <= 3'd5); // R4
endmodule

bind usb_ctl_stage_mgr usb_ctl_stage_checks u_checks (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .bus_reset_i  (bus_reset_i),
    .tok_setup_i  (tok_setup_i),
    .tok_in_i     (tok_in_i),
    .rx_end_i     (rx_end_i),
    .host_ack_i   (host_ack_i),
    .resp_valid_o (resp_valid_o),
    .resp_code_o  (resp_code_o),
    .dev_addr_o   (dev_addr_o),
    .dev_state_o  (dev_state_o),
    .stage_o      (stage_o),
    .grant_w      (grant_w),
    .hwreq_w      (hwreq_w)
);

// File: tb/sim_usb_ctl_stage_mgr.sv
`timescale 1ns/1ps
module sim_usb_ctl_stage_mgr;
    localparam int E_SETUP = 0, E_IN = 1, E_OUT = 2, E_BYTE = 3,
                   E_END = 4, E_ACK = 5, E_BRST = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_reset = 0, tok_setup = 0, tok_in = 0, tok_out = 0;
    logic rx_valid = 0, rx_end = 0, host_ack = 0, in_ready = 0, out_room = 0;
    logic [7:0]  rx_byte = '0;
    logic        cpu_we = 0;
    logic [3:0]  cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        resp_valid;
    logic [1:0]  resp_code;
    logic [6:0]  dev_addr;
    logic [1:0]  dev_state;
    logic [2:0]  stage;
    logic [3:0]  units;
    logic        irq;

    int vectors = 0, fails = 0;
    logic got_rv;
    logic [1:0] got_rc;
    logic [15:0] rd;

    always #10 clk = ~clk;

    usb_ctl_stage_mgr u0 (
        .clk_i(clk), .rst_i(rst), .bus_reset_i(bus_reset), .tok_setup_i(tok_setup),
        .tok_in_i(tok_in), .tok_out_i(tok_out), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
        .rx_end_i(rx_end), .host_ack_i(host_ack), .in_ready_i(in_ready), .out_room_i(out_room),
        .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata),
        .resp_valid_o(resp_valid), .resp_code_o(resp_code), .dev_addr_o(dev_addr),
        .dev_state_o(dev_state), .stage_o(stage), .ep0_units_o(units), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %0h exp %0h", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    task automatic fire(input int k, input logic [7:0] b);
        case (k)
            E_SETUP: tok_setup = 1'b1;
            E_IN:    tok_in    = 1'b1;
            E_OUT:   tok_out   = 1'b1;
            E_BYTE:  begin rx_valid = 1'b1; rx_byte = b; end
            E_END:   rx_end    = 1'b1;
            E_ACK:   host_ack  = 1'b1;
            default: bus_reset = 1'b1;
        endcase
        @(negedge clk);
        got_rv = resp_valid;
        got_rc = resp_code;
        tok_setup = 0; tok_in = 0; tok_out = 0; rx_valid = 0;
        rx_end = 0; host_ack = 0; bus_reset = 0;
    endtask

    task automatic cpu_wr(input logic [3:0] a, input logic [15:0] d);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic cpu_rd(input logic [3:0] a, output logic [15:0] d);
        cpu_addr = a;
        #1;
        d = cpu_rdata;
    endtask

    task automatic setup_body(input logic [7:0] rt, input logic [7:0] rq,
                              input logic [15:0] v, input logic [15:0] ix, input logic [15:0] ln);
        fire(E_BYTE, rt); fire(E_BYTE, rq);
        fire(E_BYTE, v[7:0]);  fire(E_BYTE, v[15:8]);
        fire(E_BYTE, ix[7:0]); fire(E_BYTE, ix[15:8]);
        fire(E_BYTE, ln[7:0]); fire(E_BYTE, ln[15:8]);
        fire(E_END, 8'h00);
        chk("R3 setup ack", {got_rv, got_rc}, {1'b1, 2'd0});
    endtask

    task automatic setup(input logic [7:0] rt, input logic [7:0] rq,
                         input logic [15:0] v, input logic [15:0] ix, input logic [15:0] ln);
        fire(E_SETUP, 8'h00);
        setup_body(rt, rq, v, ix, ln);
    endtask

    initial begin
        #(20 * 150000);
        vectors++; fails++;
        $display("FAIL watchdog got timeout exp completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 dev", dev_state, 0); chk("R1 addr", dev_addr, 0);
        chk("R1 stage", stage, 0);   chk("R1 irq", irq, 0);
        chk("R1 units", units, 1);
        cpu_rd(4, rd); chk("R1 cause", rd, 0);
        fire(E_IN, 0); chk("R1 powered ignores IN", got_rv, 0);
        fire(E_SETUP, 0); chk("R1 powered ignores SETUP", stage, 0);

        // R2 bus reset
        fire(E_BRST, 0);
        chk("R2 dev", dev_state, 1); chk("R2 stage", stage, 0);
        cpu_rd(4, rd); chk("R2 dev cause", rd, 16'h0002);
        // R12 masking and W1C
        cpu_wr(5, 16'h0007); chk("R12 irq on", irq, 1);
        cpu_wr(4, 16'h0002); chk("R12 irq off", irq, 0);
        cpu_rd(4, rd); chk("R12 cleared", rd, 0);

        // R4 R5 R6 R7 sweep of request type, number, length and readiness
        for (int t = 0; t < 4; t++) begin
            for (int q = 0; q < 3; q++) begin
                for (int l = 0; l < 2; l++) begin
                    logic [7:0] rt, rq;
                    logic [15:0] ln, v, ix;
                    logic hw;
                    logic [2:0] es;
                    logic [2:0] exp_code;
                    rt = (t == 0) ? 8'h00 : (t == 1) ? 8'h80 : (t == 2) ? 8'h21 : 8'hC0;
                    rq = (q == 0) ? 8'h05 : (q == 1) ? 8'h09 : 8'h06;
                    ln = (l == 0) ? 16'd0 : 16'h0012;
                    v  = 16'(t * 16 + q * 4 + l);
                    ix = 16'hA500 + v;
                    in_ready = l[0] ^ t[0];
                    hw = (rt == 8'h00) && (rq == 8'h05 || rq == 8'h09);
                    es = (hw || ln == 0) ? 3'd4 : rt[7] ? 3'd2 : 3'd3;
                    cpu_wr(4, 16'h0007);
                    setup(rt, rq, v, ix, ln);
                    chk("R4 next stage", stage, es);
                    cpu_rd(4, rd); chk("R4 stage cause", rd[0], 1);
                    cpu_rd(0, rd); chk("R3 req reg", rd, {rq, rt});
                    cpu_rd(1, rd); chk("R3 value reg", rd, v);
                    cpu_rd(2, rd); chk("R3 index reg", rd, ix);
                    cpu_rd(3, rd); chk("R3 length reg", rd, ln);
                    fire(E_IN, 0);
                    if (es == 3'd4)      exp_code = hw ? 3'd3 : 3'd1;
                    else if (es == 3'd2) exp_code = in_ready ? 3'd2 : 3'd1;
                    else                 exp_code = 3'd1;
                    chk("R5 R6 R7 first IN answer", {got_rv, got_rc}, {1'b1, exp_code[1:0]});
                    chk("R6 IN moves data-out", stage, (es == 3'd3) ? 3'd4 : es);
                end
            end
        end

        // R3 short setup packet ignored
        fire(E_SETUP, 0);
        for (int i = 0; i < 5; i++) fire(E_BYTE, 8'hEE);
        fire(E_END, 0);
        chk("R3 short no response", got_rv, 0);
        cpu_rd(0, rd); chk("R3 short keeps req", rd, 16'h06C0);

        // control write: R6 R7 R8
        setup(8'h40, 8'h07, 16'h0000, 16'h0000, 16'h0004);
        chk("R4 write stage", stage, 3);
        out_room = 1;
        fire(E_OUT, 0); for (int i = 0; i < 4; i++) fire(E_BYTE, 8'(i)); fire(E_END, 0);
        chk("R6 room ack", {got_rv, got_rc}, 3'b100);
        out_room = 0;
        fire(E_OUT, 0); for (int i = 0; i < 4; i++) fire(E_BYTE, 8'(i)); fire(E_END, 0);
        chk("R6 no room nak", {got_rv, got_rc}, 3'b101);
        fire(E_IN, 0); chk("R7 status nak", {got_rv, got_rc}, 3'b101);
        chk("R6 to status-in", stage, 4);
        cpu_wr(6, 16'h0005);
        chk("R7 units", units, 2);
        cpu_rd(6, rd); chk("R7 ctl", rd, 16'h0005);
        fire(E_IN, 0); chk("R7 status zlp", {got_rv, got_rc}, 3'b111);
        cpu_wr(4, 16'h0007);
        fire(E_ACK, 0); chk("R8 idle", stage, 0);
        cpu_rd(4, rd); chk("R8 done cause", rd[2], 1);

        // control read: R5 R7 R8
        setup(8'h80, 8'h06, 16'h0100, 16'h0000, 16'h0040);
        cpu_rd(6, rd); chk("R7 grant cleared by setup", rd[0], 0);
        in_ready = 1; fire(E_IN, 0); chk("R5 data", {got_rv, got_rc}, 3'b110);
        fire(E_ACK, 0); chk("R5 ack stays", stage, 2);
        in_ready = 0; fire(E_IN, 0); chk("R5 nak", {got_rv, got_rc}, 3'b101);
        fire(E_OUT, 0); chk("R5 to status-out", stage, 5);
        fire(E_END, 0); chk("R7 status-out nak", {got_rv, got_rc}, 3'b101);
        chk("R7 held", stage, 5);
        cpu_wr(6, 16'h0003);
        cpu_wr(4, 16'h0007);
        fire(E_OUT, 0); fire(E_END, 0);
        chk("R8 status-out ack", {got_rv, got_rc}, 3'b100);
        chk("R8 idle", stage, 0);
        cpu_rd(4, rd); chk("R8 done", rd[2], 1);

        // Set Address: grant write during setup ignored (R7), delayed commit (R9)
        fire(E_SETUP, 0);
        chk("R11 setup stage", stage, 1);
        cpu_wr(6, 16'h0003);
        cpu_rd(6, rd); chk("R7 grant in setup ignored", rd[0], 0);
        setup_body(8'h00, 8'h05, 16'h002A, 16'h0000, 16'h0000);
        chk("R9 addr held", dev_addr, 0);
        fire(E_IN, 0); chk("R9 hw zlp", {got_rv, got_rc}, 3'b111);
        chk("R9 addr held after zlp", dev_addr, 0);
        cpu_wr(4, 16'h0007);
        fire(E_ACK, 0);
        chk("R9 addr", dev_addr, 7'h2A); chk("R9 state", dev_state, 2);
        cpu_rd(4, rd); chk("R9 dev cause", rd[1], 1);
        cpu_rd(8, rd); chk("R9 addr reg", rd, 16'h002A);

        // Set Configuration R10
        setup(8'h00, 8'h09, 16'h0001, 16'h0000, 16'h0000);
        fire(E_IN, 0); fire(E_ACK, 0); chk("R10 configured", dev_state, 3);
        setup(8'h00, 8'h09, 16'h0000, 16'h0000, 16'h0000);
        fire(E_IN, 0); fire(E_ACK, 0); chk("R10 back to addressed", dev_state, 2);
        cpu_rd(7, rd); chk("R10 status reg", rd, 16'h0002);

        // R11 abort mid data stage
        setup(8'h80, 8'h06, 16'h0200, 16'h0000, 16'h0040);
        fire(E_SETUP, 0); chk("R11 abort to setup", stage, 1);
        setup_body(8'hC0, 8'h33, 16'h7777, 16'h8888, 16'h0010);
        cpu_rd(1, rd); chk("R11 value overwritten", rd, 16'h7777);
        chk("R11 new stage", stage, 2);

        // R12 mask selects causes
        cpu_wr(5, 16'h0004);
        cpu_wr(4, 16'h0007);
        setup(8'h21, 8'h01, 16'h0000, 16'h0000, 16'h0000);
        cpu_rd(4, rd); chk("R12 stage pending", rd[0], 1);
        chk("R12 masked irq", irq, 0);
        cpu_wr(6, 16'h0001); fire(E_IN, 0); fire(E_ACK, 0);
        chk("R12 done irq", irq, 1);

        // R2 bus reset from configured-style state
        fire(E_BRST, 0);
        chk("R2 addr cleared", dev_addr, 0); chk("R2 default", dev_state, 1);
        cpu_rd(6, rd); chk("R2 grant cleared", rd[0], 0);

        summary();
    end
endmodule